// File: doc/BRIEF.md
# Auto-Reload Periodic Wakeup Timer

This block is a periodic wakeup timer. It counts down from a 17-bit reload value. Each time the count passes zero it raises a sticky expiry flag and reloads itself from the reload register. The timer advances on timer cycles. A select input picks the source of those cycles: every clock of the RTC clock, or a one-cycle pulse of a 1 Hz tick that arrives in the same clock domain. With the 1 Hz source, the period runs from 1 s to about 36 hours.

The enable bit comes from the register side and is treated as asynchronous. It passes through two RTC-clock stages, then two timer-cycle stages, then one start stage, and only then does down-counting begin. Two status outputs support reload updates. The write-allowed status says that the enable pipeline is fully idle, so the reload value may be written. The enable-synced status says that counting has begun. An interrupt output gates the flag with an interrupt enable. Only the RTC-domain reset initialises the block; system reset is not connected to it.

All pins are plain control and status signals. There is no data stream, so no valid/ready handshake applies.

Top module: `wkup_timer`

## Requirements
- R1: After the RTC-domain reset, the flag, the interrupt and the enable-synced status are 0 and the write-allowed status is 1.
- R2: Counting starts at the edge of the 1st timer cycle after a rise of `en_i` has been sampled by 2 clock stages and then 2 timer-cycle stages. The enable-synced status sets at that same edge.
- R3: While counting, the flag sets on every (reload+1)-th timer cycle after counting starts. The count then reloads automatically, so a reload of 0 expires on every timer cycle.
- R4: With `src_sel_i`=0 every clock is a timer cycle. With `src_sel_i`=1 only clocks with `tick_i`=1 are timer cycles.
- R5: The flag stays set until `flag_clr_i`=1. An expiry in the same cycle as a clear leaves the flag set.
- R6: `irq_o` is 1 exactly when the flag is set and `irq_en_i`=1.
- R7: The write-allowed status is 1 only when every enable-pipeline stage has been idle for a clock. It falls at the 2nd clock edge after `en_i` rises.
- R8: A reload write (`reload_we_i`=1) takes effect only when the write-allowed status is 1; otherwise it is ignored.
- R9: The enable-synced status is cleared by `synced_clr_i` or `init_mode_i`. A start in the same cycle wins over the clear.
- R10: Once the disable has passed through the pipeline, the counter stops and reloads, and the flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RTC clock |
| rst_n | input | 1 | RTC-domain reset, active low |
| en_i | input | 1 | Timer enable from the register side (asynchronous) |
| reload_i | input | 17 | Reload value to write |
| reload_we_i | input | 1 | Reload write strobe |
| src_sel_i | input | 1 | Timer-cycle source: 0 = RTC clock, 1 = 1 Hz tick |
| tick_i | input | 1 | 1 Hz tick pulse, one clock wide |
| flag_clr_i | input | 1 | Software clear of the flag |
| irq_en_i | input | 1 | Interrupt enable |
| synced_clr_i | input | 1 | Software clear of the enable-synced status |
| init_mode_i | input | 1 | Init mode; clears the enable-synced status |
| flag_o | output | 1 | Sticky expiry flag |
| irq_o | output | 1 | Interrupt request |
| wr_ok_o | output | 1 | Reload may be written |
| en_synced_o | output | 1 | Enable has taken effect |

## Verification
Two pairs of events can fall in the same cycle: an expiry and a software flag clear, and a counting start and a synced-status clear. With a reload of 3, or of 0, and `flag_clr_i` held high for many cycles, expiries are forced onto clear cycles. The same applies to `synced_clr_i` held across a re-enable. A behavioural reference model advanced on every clock judges each collision: the set must win, the flag must read 1 on that cycle, and it must drop on the next clear-only cycle. Reload writes attempted while counting must leave the observed period unchanged.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
  localparam int unsigned RLD_W_DEF   = 17;
  localparam int unsigned RTC_STG_DEF = 2;
  localparam int unsigned TMR_STG_DEF = 2;
endpackage

// File: rtl/wkup_en_sync.sv
module wkup_en_sync #(
  parameter int unsigned RTC_STG = 2,
  parameter int unsigned TMR_STG = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_async,
  input  logic tmr_tick,
  output logic run_o,
  output logic start_o,
  output logic busy_o
);
  logic [RTC_STG-1:0] rsync;
  logic [TMR_STG-1:0] tsync;
  logic               run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync <= '0;
      tsync <= '0;
      run_q <= 1'b0;
    end else begin
      rsync <= {rsync[RTC_STG-2:0], en_async};
      if (tmr_tick) begin
        tsync <= {tsync[TMR_STG-2:0], rsync[RTC_STG-1]};
        run_q <= tsync[TMR_STG-1];
      end
    end
  end

  assign run_o   = run_q;
  assign start_o = tmr_tick & tsync[TMR_STG-1] & ~run_q;
  assign busy_o  = (|rsync) | (|tsync) | run_q;

  // R2: run only changes on a timer cycle
  assert_run_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_tick |=> $stable(run_q));
endmodule

// File: rtl/wkup_down_cnt.sv
module wkup_down_cnt #(
  parameter int unsigned RLD_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tmr_tick,
  input  logic [RLD_W-1:0] reload,
  output logic             expire_o
);
  logic [RLD_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= reload;
    else if (tmr_tick) cnt <= (cnt == '0) ? reload : cnt - 1'b1;
  end

  assign expire_o = run & tmr_tick & (cnt == '0);

  // R10: stopped counter follows the reload register
  assert_stop_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == $past(reload)));
endmodule

// File: rtl/wkup_status.sv
module wkup_status (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic expire,
  input  logic start,
  input  logic flag_clr,
  input  logic synced_clr,
  input  logic init_mode,
  output logic wr_ok_o,
  output logic flag_o,
  output logic synced_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ok_o  <= 1'b1;
      flag_o   <= 1'b0;
      synced_o <= 1'b0;
    end else begin
      wr_ok_o <= ~busy;
      if (expire)        flag_o <= 1'b1;
      else if (flag_clr) flag_o <= 1'b0;
      if (start)                        synced_o <= 1'b1;
      else if (synced_clr || init_mode) synced_o <= 1'b0;
    end
  end

  // R5: flag is sticky without a clear
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !flag_clr) |=> flag_o);
  // R9: start beats a simultaneous clear
  assert_start_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> synced_o);
endmodule

// File: rtl/wkup_timer.sv
module wkup_timer #(
  parameter int unsigned RLD_W   = wkup_pkg::RLD_W_DEF,
  parameter int unsigned RTC_STG = wkup_pkg::RTC_STG_DEF,
  parameter int unsigned TMR_STG = wkup_pkg::TMR_STG_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [RLD_W-1:0] reload_i,
  input  logic             reload_we_i,
  input  logic             src_sel_i,
  input  logic             tick_i,
  input  logic             flag_clr_i,
  input  logic             irq_en_i,
  input  logic             synced_clr_i,
  input  logic             init_mode_i,
  output logic             flag_o,
  output logic             irq_o,
  output logic             wr_ok_o,
  output logic             en_synced_o
);
  logic             tmr_tick, run, start, busy, expire;
  logic [RLD_W-1:0] reload_q;

  assign tmr_tick = src_sel_i ? tick_i : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      reload_q <= '0;
    else if (reload_we_i && wr_ok_o) reload_q <= reload_i;
  end

  wkup_en_sync #(.RTC_STG(RTC_STG), .TMR_STG(TMR_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .en_async(en_i), .tmr_tick(tmr_tick),
    .run_o(run), .start_o(start), .busy_o(busy)
  );

  wkup_down_cnt #(.RLD_W(RLD_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .tmr_tick(tmr_tick),
    .reload(reload_q), .expire_o(expire)
  );

  wkup_status u_stat (
    .clk(clk), .rst_n(rst_n), .busy(busy), .expire(expire), .start(start),
    .flag_clr(flag_clr_i), .synced_clr(synced_clr_i), .init_mode(init_mode_i),
    .wr_ok_o(wr_ok_o), .flag_o(flag_o), .synced_o(en_synced_o)
  );

  assign irq_o = flag_o & irq_en_i;

  // R7: never write-allowed while counting
  assert_no_wr_while_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> !wr_ok_o);
  // R8: reload frozen while writes are locked
  assert_reload_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ok_o |=> $stable(reload_q));
  // R3: flag rises only from a running counter
  assert_flag_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(run));
  // R2: synced status rises only as counting starts
  assert_synced_with_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_synced_o) |-> run);
endmodule

// File: tb/wkup_timer_test.sv
`timescale 1ns/1ps
module wkup_timer_test;
  localparam int W = 17;
  logic clk = 0, rst_n = 0;
  logic en_i = 0, reload_we_i = 0, src_sel_i = 0, tick_i = 0;
  logic flag_clr_i = 0, irq_en_i = 0, synced_clr_i = 0, init_mode_i = 0;
  logic [W-1:0] reload_i = '0;
  logic flag_o, irq_o, wr_ok_o, en_synced_o;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0, tick_gen = 0;

  always #2.5 clk = ~clk;

  wkup_timer uut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .reload_i(reload_i),
    .reload_we_i(reload_we_i), .src_sel_i(src_sel_i), .tick_i(tick_i),
    .flag_clr_i(flag_clr_i), .irq_en_i(irq_en_i), .synced_clr_i(synced_clr_i),
    .init_mode_i(init_mode_i), .flag_o(flag_o), .irq_o(irq_o),
    .wr_ok_o(wr_ok_o), .en_synced_o(en_synced_o)
  );

  // behavioural reference: enable history, tick pipeline, remaining count
  bit m_c0, m_c1, m_t0, m_t1, m_run, m_flag, m_syn, m_wr;
  int m_cnt, m_rld;
  always @(posedge clk) begin
    bit tk, nwr, ex, st;
    cyc++;
    if (!rst_n) begin
      {m_c0, m_c1, m_t0, m_t1, m_run, m_flag, m_syn} = '0;
      m_wr = 1; m_cnt = 0; m_rld = 0;
    end else begin
      tk  = src_sel_i ? tick_i : 1'b1;
      nwr = !(m_c0 | m_c1 | m_t0 | m_t1 | m_run);
      ex  = m_run && tk && (m_cnt == 0);
      st  = tk && m_t1 && !m_run;
      if (!m_run) m_cnt = m_rld;
      else if (tk) m_cnt = (m_cnt == 0) ? m_rld : m_cnt - 1;
      if (ex) m_flag = 1; else if (flag_clr_i) m_flag = 0;
      if (st) m_syn = 1; else if (synced_clr_i || init_mode_i) m_syn = 0;
      if (reload_we_i && m_wr) m_rld = int'(reload_i);
      m_wr = nwr;
      if (tk) begin m_run = m_t1; m_t1 = m_t0; m_t0 = m_c1; end
      m_c1 = m_c0; m_c0 = en_i;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", req, cyc, act, exp);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) if (rst_n && !done) begin
    chk("R5 flag", flag_o, m_flag);
    chk("R6 irq", irq_o, m_flag & irq_en_i);
    chk("R7 wr_ok", wr_ok_o, m_wr);
    chk("R2/R9 synced", en_synced_o, m_syn);
  end

  always @(posedge clk) begin
    #1 tick_i <= tick_gen && (cyc % 5 == 0);
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    @(negedge clk);
    // R1: reset values
    chk("R1 flag", flag_o, 1'b0);
    chk("R1 irq", irq_o, 1'b0);
    chk("R1 wr_ok", wr_ok_o, 1'b1);
    chk("R1 synced", en_synced_o, 1'b0);
    step(1);
    // R8: write allowed while idle; R3/R4: period 4 on every clock
    reload_i = 3; reload_we_i = 1; step(1); reload_we_i = 0;
    irq_en_i = 1;
    en_i = 1;
    step(2);
    @(negedge clk); chk("R7 wr_ok low two clocks after enable", wr_ok_o, 1'b0);
    step(20);
    // R8: write while counting must be ignored
    reload_i = 9; reload_we_i = 1; step(1); reload_we_i = 0;
    step(12);
    // R5: clear held across expiries, collisions
    flag_clr_i = 1; step(20); flag_clr_i = 0;
    step(3);
    irq_en_i = 0; step(4); irq_en_i = 1; // R6
    // R9: software and init-mode clears
    synced_clr_i = 1; step(1); synced_clr_i = 0; step(2);
    // R10: disable, flag holds, counter stops
    en_i = 0; step(12);
    init_mode_i = 1; step(1); init_mode_i = 0;
    // R3: reload 0 expires every cycle, clear and start collide (R5, R9)
    reload_i = 0; reload_we_i = 1; step(1); reload_we_i = 0;
    synced_clr_i = 1; flag_clr_i = 1; en_i = 1;
    step(12); synced_clr_i = 0; step(4); flag_clr_i = 0;
    step(5);
    en_i = 0; step(10);
    // R4: 1 Hz tick source, reload 2
    src_sel_i = 1; tick_gen = 1;
    reload_i = 2; reload_we_i = 1; step(1); reload_we_i = 0;
    flag_clr_i = 1; step(1); flag_clr_i = 0;
    en_i = 1; step(60);
    flag_clr_i = 1; step(1); flag_clr_i = 0;
    step(40);
    en_i = 0; step(40);
    finish_run();
  end
endmodule